// File: doc/BRIEF.md
# Speculative Block Directory with Dependence Checking

This block is the home directory for a small set of memory blocks in a 16-node shared-memory machine that runs tasks speculatively. For each block it holds a protocol state (uncached, shared, private or speculative), a non-speculative sharer vector, and two separate vectors that record which nodes have read the block speculatively and which have written it speculatively. Commands arrive one per cycle. Each command names a block index, a node identifier and an operation.

Node identifiers give the program order, and the directory handles all commands in order. When a speculative write arrives, the block compares the writer against the recorded readers. A reader with a higher identifier has read a value too early. The block then produces a squash mask that covers every node from that reader upward. It sends no check to the sharers. Conflicts between two writers, and a write that follows a read, are resolved by renaming and never raise a violation. When an earlier writer exists, the response names the latest one as the forwarding source. A reconcile-flush command returns a speculative block to the uncached state.

The result of every command appears on a registered response port one cycle later. Data movement, packet handling and the merge of speculative versions are handled elsewhere.

Top module: `spec_dir_ctrl`

## Requirements
- R1: Reset makes every entry uncached with empty sharer, reader and writer vectors and holds `rsp_valid` low. An entry that was speculative before reset reports only the new requester after the first speculative command that follows reset.
- R2: Non-speculative protocol. Op 0 (plain read) moves an uncached or shared block to shared (state 1) and adds the requester. On a private block (state 2) owned by another node it raises `rsp_writeback` and goes to shared. Op 1 (plain write) moves the block to private with the requester as sole sharer. `rsp_inval` carries the other sharers, and `rsp_writeback` rises if another node owned the block.
- R3: A speculative read (op 2) or write (op 3) to a non-speculative block invalidates all current sharers through `rsp_inval`. It raises `rsp_writeback` if the block was private, clears all vectors, and moves the block to speculative (state 3).
- R4: Each speculative read sets the requester's bit in `rsp_readers`, and each speculative write sets it in `rsp_writers`. Bits set earlier are kept.
- R5: On a speculative write from node W, let R be the smallest reader identifier greater than W. If such an R exists, `rsp_violation` is 1 and `rsp_squash` has bits R through 15 set. Otherwise both are zero.
- R6: Write-after-write conflicts cause no violation. A write that follows a read by the same node or by a lower node causes no violation either.
- R7: On a speculative read or write, `rsp_fwd_valid` is 1 exactly when some writer with an identifier below the requester is recorded. `rsp_fwd_node` then names the highest such writer.
- R8: A reconcile-flush (op 4) on a speculative block makes it uncached (state 0) and clears its vectors. A flush on a non-speculative block has no effect.
- R9: Plain reads and writes to a speculative block have no effect. The state and the vectors are unchanged, and no invalidation or writeback is reported.
- R10: Every command accepted with `cmd_valid` high produces exactly one response, with `rsp_valid` high on the following cycle. Back-to-back commands to the same block see each other's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 plain read, 1 plain write, 2 spec read, 3 spec write, 4 reconcile-flush |
| cmd_block | input | 3 | Directory entry index |
| cmd_node | input | 4 | Requester identifier (program order) |
| rsp_valid | output | 1 | Response present |
| rsp_state | output | 2 | Resulting state: 0 uncached, 1 shared, 2 private, 3 speculative |
| rsp_readers | output | 16 | Speculative reader vector after the command |
| rsp_writers | output | 16 | Speculative writer vector after the command |
| rsp_inval | output | 16 | Sharers to invalidate |
| rsp_writeback | output | 1 | Dirty owner must write back |
| rsp_violation | output | 1 | Read-after-write ordering violation detected |
| rsp_squash | output | 16 | Nodes to squash |
| rsp_fwd_valid | output | 1 | An earlier writer supplies the data |
| rsp_fwd_node | output | 4 | Identifier of that writer |

## Verification
The hardest case to reach is a write that lands between readers, where only the nearest later reader must set the edge of the squash mask. A low node at or below the writer, or a node that is both reader and writer, must not move that edge. The vector table first builds one block with readers on both sides of several writers and a writer that was also a reader. It then issues writes from below, between and above the readers, and checks each mask edge and forwarding source. A flushed block is reused later to show that its old vectors are gone, and two back-to-back commands to one block confirm that the second sees the first.

// File: rtl/dir_spec_pkg.sv
package dir_spec_pkg;
  typedef enum logic [2:0] {
    OP_PRD   = 3'd0,
    OP_PWR   = 3'd1,
    OP_SRD   = 3'd2,
    OP_SWR   = 3'd3,
    OP_FLUSH = 3'd4
  } dir_op_e;

  typedef enum logic [1:0] {
    ST_UNC = 2'd0,
    ST_SHR = 2'd1,
    ST_PRV = 2'd2,
    ST_SPC = 2'd3
  } dir_state_e;
endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store
  import dir_spec_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NODES   = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output dir_state_e       rd_state,
  output logic [NODES-1:0] rd_sharers,
  output logic [NODES-1:0] rd_readers,
  output logic [NODES-1:0] rd_writers,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  dir_state_e       wr_state,
  input  logic [NODES-1:0] wr_sharers,
  input  logic [NODES-1:0] wr_readers,
  input  logic [NODES-1:0] wr_writers
);
  dir_state_e       st_mem [ENTRIES];
  logic [NODES-1:0] sh_mem [ENTRIES];
  logic [NODES-1:0] rd_mem [ENTRIES];
  logic [NODES-1:0] wr_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        st_mem[e] <= ST_UNC;
        sh_mem[e] <= '0;
        rd_mem[e] <= '0;
        wr_mem[e] <= '0;
      end
    end else if (wr_en) begin
      st_mem[wr_idx] <= wr_state;
      sh_mem[wr_idx] <= wr_sharers;
      rd_mem[wr_idx] <= wr_readers;
      wr_mem[wr_idx] <= wr_writers;
    end
  end

  assign rd_state   = st_mem[rd_idx];
  assign rd_sharers = sh_mem[rd_idx];
  assign rd_readers = rd_mem[rd_idx];
  assign rd_writers = wr_mem[rd_idx];
endmodule

// File: rtl/dir_raw_check.sv
module dir_raw_check #(
  parameter int NODES  = 16,
  localparam int ID_W  = $clog2(NODES)
) (
  input  logic             chk_en,
  input  logic             fwd_en,
  input  logic [ID_W-1:0]  node,
  input  logic [NODES-1:0] readers,
  input  logic [NODES-1:0] writers,
  output logic             violation,
  output logic [NODES-1:0] squash,
  output logic             fwd_valid,
  output logic [ID_W-1:0]  fwd_node
);
  logic            later_found;
  logic [ID_W-1:0] later_id;

  // Nearest reader above the writer: scan downward so the lowest wins.
  always_comb begin
    later_found = 1'b0;
    later_id    = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (i > int'(node) && readers[i]) begin
        later_found = 1'b1;
        later_id    = ID_W'(i);
      end
    end
  end

  assign violation = chk_en && later_found;

  for (genvar g = 0; g < NODES; g++) begin : g_sq
    assign squash[g] = violation && (ID_W'(g) >= later_id);
  end

  // Latest earlier writer: scan upward so the highest wins.
  always_comb begin
    fwd_valid = 1'b0;
    fwd_node  = '0;
    for (int i = 0; i < NODES; i++) begin
      if (fwd_en && i < int'(node) && writers[i]) begin
        fwd_valid = 1'b1;
        fwd_node  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/dir_next_state.sv
module dir_next_state
  import dir_spec_pkg::*;
#(
  parameter int NODES = 16,
  localparam int ID_W = $clog2(NODES)
) (
  input  dir_op_e          op,
  input  logic             valid,
  input  logic [ID_W-1:0]  node,
  input  dir_state_e       cur_state,
  input  logic [NODES-1:0] cur_sharers,
  input  logic [NODES-1:0] cur_readers,
  input  logic [NODES-1:0] cur_writers,
  output logic             upd_en,
  output dir_state_e       nxt_state,
  output logic [NODES-1:0] nxt_sharers,
  output logic [NODES-1:0] nxt_readers,
  output logic [NODES-1:0] nxt_writers,
  output logic [NODES-1:0] inval,
  output logic             writeback
);
  logic [NODES-1:0] req_bit;
  logic             is_spec;

  assign req_bit = NODES'(1) << node;
  assign is_spec = (cur_state == ST_SPC);

  always_comb begin
    upd_en      = 1'b0;
    nxt_state   = cur_state;
    nxt_sharers = cur_sharers;
    nxt_readers = cur_readers;
    nxt_writers = cur_writers;
    inval       = '0;
    writeback   = 1'b0;
    if (valid) begin
      unique case (op)
        OP_PRD: if (!is_spec) begin
          upd_en = 1'b1;
          if (cur_state == ST_PRV && cur_sharers == req_bit) begin
            nxt_state = ST_PRV;
          end else begin
            writeback   = (cur_state == ST_PRV);
            nxt_state   = ST_SHR;
            nxt_sharers = cur_sharers | req_bit;
          end
        end
        OP_PWR: if (!is_spec) begin
          upd_en      = 1'b1;
          inval       = cur_sharers & ~req_bit;
          writeback   = (cur_state == ST_PRV) && (cur_sharers != req_bit);
          nxt_state   = ST_PRV;
          nxt_sharers = req_bit;
        end
        OP_SRD, OP_SWR: begin
          upd_en = 1'b1;
          if (!is_spec) begin
            inval       = cur_sharers;
            writeback   = (cur_state == ST_PRV);
            nxt_sharers = '0;
            nxt_readers = '0;
            nxt_writers = '0;
          end
          nxt_state = ST_SPC;
          if (op == OP_SRD) nxt_readers = (is_spec ? cur_readers : '0) | req_bit;
          else              nxt_writers = (is_spec ? cur_writers : '0) | req_bit;
        end
        OP_FLUSH: if (is_spec) begin
          upd_en      = 1'b1;
          nxt_state   = ST_UNC;
          nxt_sharers = '0;
          nxt_readers = '0;
          nxt_writers = '0;
        end
        default: upd_en = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/spec_dir_ctrl.sv
module spec_dir_ctrl
  import dir_spec_pkg::*;
#(
  parameter int NODES   = 16,
  parameter int ENTRIES = 8,
  localparam int ID_W   = $clog2(NODES),
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_block,
  input  logic [ID_W-1:0]  cmd_node,
  output logic             rsp_valid,
  output logic [1:0]       rsp_state,
  output logic [NODES-1:0] rsp_readers,
  output logic [NODES-1:0] rsp_writers,
  output logic [NODES-1:0] rsp_inval,
  output logic             rsp_writeback,
  output logic             rsp_violation,
  output logic [NODES-1:0] rsp_squash,
  output logic             rsp_fwd_valid,
  output logic [ID_W-1:0]  rsp_fwd_node
);
  dir_op_e          op;
  dir_state_e       cur_state, nxt_state;
  logic [NODES-1:0] cur_sh, cur_rd, cur_wr;
  logic [NODES-1:0] nxt_sh, nxt_rd, nxt_wr;
  logic [NODES-1:0] base_rd, base_wr;
  logic [NODES-1:0] inval, squash;
  logic             upd_en, writeback, violation, fwd_valid;
  logic [ID_W-1:0]  fwd_node;
  logic             spec_cmd;

  assign op       = dir_op_e'(cmd_op);
  assign spec_cmd = cmd_valid && (op == OP_SRD || op == OP_SWR);
  // Vectors of a non-speculative entry do not take part in the checks.
  assign base_rd  = (cur_state == ST_SPC) ? cur_rd : '0;
  assign base_wr  = (cur_state == ST_SPC) ? cur_wr : '0;

  dir_entry_store #(.ENTRIES(ENTRIES), .NODES(NODES)) u_store (
    .clk(clk), .rst(rst),
    .rd_idx(cmd_block), .rd_state(cur_state),
    .rd_sharers(cur_sh), .rd_readers(cur_rd), .rd_writers(cur_wr),
    .wr_en(upd_en), .wr_idx(cmd_block), .wr_state(nxt_state),
    .wr_sharers(nxt_sh), .wr_readers(nxt_rd), .wr_writers(nxt_wr)
  );

  dir_next_state #(.NODES(NODES)) u_next (
    .op(op), .valid(cmd_valid), .node(cmd_node),
    .cur_state(cur_state), .cur_sharers(cur_sh),
    .cur_readers(cur_rd), .cur_writers(cur_wr),
    .upd_en(upd_en), .nxt_state(nxt_state), .nxt_sharers(nxt_sh),
    .nxt_readers(nxt_rd), .nxt_writers(nxt_wr),
    .inval(inval), .writeback(writeback)
  );

  dir_raw_check #(.NODES(NODES)) u_raw (
    .chk_en(cmd_valid && op == OP_SWR), .fwd_en(spec_cmd),
    .node(cmd_node), .readers(base_rd), .writers(base_wr),
    .violation(violation), .squash(squash),
    .fwd_valid(fwd_valid), .fwd_node(fwd_node)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_state     <= ST_UNC;
      rsp_readers   <= '0;
      rsp_writers   <= '0;
      rsp_inval     <= '0;
      rsp_writeback <= 1'b0;
      rsp_violation <= 1'b0;
      rsp_squash    <= '0;
      rsp_fwd_valid <= 1'b0;
      rsp_fwd_node  <= '0;
    end else begin
      rsp_valid     <= cmd_valid;
      rsp_state     <= cmd_valid ? nxt_state : ST_UNC;
      rsp_readers   <= cmd_valid ? nxt_rd : '0;
      rsp_writers   <= cmd_valid ? nxt_wr : '0;
      rsp_inval     <= inval;
      rsp_writeback <= writeback;
      rsp_violation <= violation;
      rsp_squash    <= squash;
      rsp_fwd_valid <= fwd_valid;
      rsp_fwd_node  <= fwd_node;
    end
  end
endmodule

// File: rtl/spec_dir_ctrl_chk.sv
module spec_dir_ctrl_chk #(
  parameter int NODES = 16,
  localparam int ID_W = $clog2(NODES)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             rsp_valid,
  input logic [1:0]       rsp_state,
  input logic [NODES-1:0] rsp_readers,
  input logic [NODES-1:0] rsp_writers,
  input logic             rsp_violation,
  input logic [NODES-1:0] rsp_squash,
  input logic             rsp_fwd_valid,
  input logic [ID_W-1:0]  rsp_fwd_node
);
  assert_rsp_follows_cmd_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid);
  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !rsp_valid);
  assert_squash_reaches_top_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_violation |-> rsp_squash[NODES-1]);
  assert_squash_only_on_violation_R5: assert property (@(posedge clk) disable iff (rst)
    !rsp_violation |-> rsp_squash == '0);
  assert_violation_from_spec_write_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_violation |-> $past(cmd_op) == 3'd3);
  assert_fwd_is_recorded_writer_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_fwd_valid |-> (rsp_writers[rsp_fwd_node] && rsp_state == 2'd3));
  assert_nonspec_vectors_empty_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_state != 2'd3) |-> (rsp_readers == '0 && rsp_writers == '0));
  assert_spec_has_member_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_state == 2'd3) |-> (rsp_readers | rsp_writers) != '0);
endmodule

bind spec_dir_ctrl spec_dir_ctrl_chk #(.NODES(NODES)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rsp_valid(rsp_valid), .rsp_state(rsp_state),
  .rsp_readers(rsp_readers), .rsp_writers(rsp_writers),
  .rsp_violation(rsp_violation), .rsp_squash(rsp_squash),
  .rsp_fwd_valid(rsp_fwd_valid), .rsp_fwd_node(rsp_fwd_node)
);

// File: tb/spec_dir_ctrl_test.sv
module spec_dir_ctrl_test;
  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  blk;
    logic [3:0]  node;
    logic [1:0]  st;
    logic        viol;
    logic [15:0] sq;
    logic        fv;
    logic [3:0]  fn;
    logic [15:0] rd;
    logic [15:0] wr;
    logic [15:0] inv;
    logic        wb;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  // op, blk, node, state, viol, squash, fwd_v, fwd_n, readers, writers, inval, wb, req
  localparam vec_t TBL [NV] = '{
    '{3'd0,3'd0,4'd2, 2'd1,1'b0,16'h0000,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,4'd2},  // R2
    '{3'd0,3'd0,4'd5, 2'd1,1'b0,16'h0000,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,4'd2},  // R2
    '{3'd2,3'd0,4'd7, 2'd3,1'b0,16'h0000,1'b0,4'd0,16'h0080,16'h0000,16'h0024,1'b0,4'd3},  // R3
    '{3'd2,3'd0,4'd9, 2'd3,1'b0,16'h0000,1'b0,4'd0,16'h0280,16'h0000,16'h0000,1'b0,4'd4},  // R4
    '{3'd3,3'd0,4'd3, 2'd3,1'b1,16'hFF80,1'b0,4'd0,16'h0280,16'h0008,16'h0000,1'b0,4'd5},  // R5
    '{3'd3,3'd0,4'd8, 2'd3,1'b1,16'hFE00,1'b1,4'd3,16'h0280,16'h0108,16'h0000,1'b0,4'd5},  // R5
    '{3'd3,3'd0,4'd12,2'd3,1'b0,16'h0000,1'b1,4'd8,16'h0280,16'h1108,16'h0000,1'b0,4'd6},  // R6
    '{3'd2,3'd0,4'd10,2'd3,1'b0,16'h0000,1'b1,4'd8,16'h0680,16'h1108,16'h0000,1'b0,4'd7},  // R7
    '{3'd3,3'd0,4'd10,2'd3,1'b0,16'h0000,1'b1,4'd8,16'h0680,16'h1508,16'h0000,1'b0,4'd6},  // R6
    '{3'd1,3'd0,4'd1, 2'd3,1'b0,16'h0000,1'b0,4'd0,16'h0680,16'h1508,16'h0000,1'b0,4'd9},  // R9
    '{3'd4,3'd0,4'd0, 2'd0,1'b0,16'h0000,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,4'd8},  // R8
    '{3'd4,3'd0,4'd0, 2'd0,1'b0,16'h0000,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,4'd8},  // R8
    '{3'd1,3'd1,4'd4, 2'd2,1'b0,16'h0000,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b0,4'd2},  // R2
    '{3'd0,3'd1,4'd6, 2'd1,1'b0,16'h0000,1'b0,4'd0,16'h0000,16'h0000,16'h0000,1'b1,4'd2},  // R2
    '{3'd1,3'd1,4'd6, 2'd2,1'b0,16'h0000,1'b0,4'd0,16'h0000,16'h0000,16'h0010,1'b0,4'd2},  // R2
    '{3'd3,3'd1,4'd0, 2'd3,1'b0,16'h0000,1'b0,4'd0,16'h0000,16'h0001,16'h0040,1'b1,4'd3},  // R3
    '{3'd2,3'd2,4'd15,2'd3,1'b0,16'h0000,1'b0,4'd0,16'h8000,16'h0000,16'h0000,1'b0,4'd4},  // R4
    '{3'd3,3'd2,4'd0, 2'd3,1'b1,16'h8000,1'b0,4'd0,16'h8000,16'h0001,16'h0000,1'b0,4'd5},  // R5
    '{3'd3,3'd2,4'd15,2'd3,1'b0,16'h0000,1'b1,4'd0,16'h8000,16'h8001,16'h0000,1'b0,4'd7},  // R7
    '{3'd3,3'd7,4'd5, 2'd3,1'b0,16'h0000,1'b0,4'd0,16'h0000,16'h0020,16'h0000,1'b0,4'd3},  // R3
    '{3'd2,3'd0,4'd0, 2'd3,1'b0,16'h0000,1'b0,4'd0,16'h0001,16'h0000,16'h0000,1'b0,4'd8},  // R8
    '{3'd2,3'd1,4'd1, 2'd3,1'b0,16'h0000,1'b1,4'd0,16'h0002,16'h0001,16'h0000,1'b0,4'd7},  // R7
    '{3'd0,3'd7,4'd2, 2'd3,1'b0,16'h0000,1'b0,4'd0,16'h0000,16'h0020,16'h0000,1'b0,4'd9}   // R9
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_block = '0;
  logic [3:0]  cmd_node = '0;
  logic        rsp_valid, rsp_writeback, rsp_violation, rsp_fwd_valid;
  logic [1:0]  rsp_state;
  logic [15:0] rsp_readers, rsp_writers, rsp_inval, rsp_squash;
  logic [3:0]  rsp_fwd_node;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  spec_dir_ctrl uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_block(cmd_block), .cmd_node(cmd_node),
    .rsp_valid(rsp_valid), .rsp_state(rsp_state),
    .rsp_readers(rsp_readers), .rsp_writers(rsp_writers),
    .rsp_inval(rsp_inval), .rsp_writeback(rsp_writeback),
    .rsp_violation(rsp_violation), .rsp_squash(rsp_squash),
    .rsp_fwd_valid(rsp_fwd_valid), .rsp_fwd_node(rsp_fwd_node)
  );

  function automatic logic [72:0] actual_rsp();
    return {rsp_state, rsp_violation, rsp_squash, rsp_fwd_valid, rsp_fwd_node,
            rsp_readers, rsp_writers, rsp_inval, rsp_writeback};
  endfunction

  task automatic check(input string tag, input logic [72:0] act, input logic [72:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [2:0] blk, input logic [3:0] node);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_block = blk;
    cmd_node  = node;
  endtask

  task automatic run_vec(input vec_t v);
    drive(v.op, v.blk, v.node);
    @(negedge clk);
    cmd_valid = 1'b0;
    check($sformatf("R%0d rsp_valid", v.req), {72'd0, rsp_valid}, 73'd1);
    check($sformatf("R%0d response", v.req), actual_rsp(),
          {v.st, v.viol, v.sq, v.fv, v.fn, v.rd, v.wr, v.inv, v.wb});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: no response after reset
    check("R1 reset rsp_valid", {72'd0, rsp_valid}, 73'd0);

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R10: idle cycle produces no response
    @(negedge clk);
    check("R10 idle rsp_valid", {72'd0, rsp_valid}, 73'd0);

    // R10: back-to-back commands to one block; second sees first's reader
    drive(3'd2, 3'd3, 4'd6);
    @(negedge clk);
    check("R10 first of pair", actual_rsp(),
          {2'd3, 1'b0, 16'h0000, 1'b0, 4'd0, 16'h0040, 16'h0000, 16'h0000, 1'b0});
    drive(3'd3, 3'd3, 4'd2);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 second of pair", actual_rsp(),
          {2'd3, 1'b1, 16'hFFC0, 1'b0, 4'd0, 16'h0040, 16'h0004, 16'h0000, 1'b0});

    // R1: reset mid-run wipes block 0 (it held reader 0)
    rst = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid in reset", {72'd0, rsp_valid}, 73'd0);
    rst = 1'b0;
    run_vec('{3'd2, 3'd0, 4'd4, 2'd3, 1'b0, 16'h0000, 1'b0, 4'd0,
              16'h0010, 16'h0000, 16'h0000, 1'b0, 4'd1});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule